// File: doc/BRIEF.md
# Interrupt-Triggered Single-Transfer Channel

This block is one channel of a hardware transfer service that takes the place of a software interrupt handler. When a peripheral raises its request, the channel moves exactly one byte or one word between a 16-bit I/O register address and a 24-bit buffer address. It then acknowledges the peripheral and updates its pointers and its transfer count. The direction, the operand size, whether each pointer advances, and whether the peripheral may end the service early are all set in a small control register.

Each transfer is a read bus cycle at the source address followed by a write bus cycle at the destination address. Each bus cycle is held until the memory side returns ready. A channel is used once for each service: software loads the pointers and the count, then enables the channel. The channel disables itself and raises a one-cycle completion interrupt when the count runs out, or when the peripheral ends the service early while that is permitted.

Top module: `irq_xfer_channel`

## Requirements
- R1: After reset, the channel is disabled, both pointers, the count and the control field are zero, and bus_req, xfer_ack and done_irq are low.
- R2: A register write with cfg_sel 0 loads the control field from cfg_wdata[4:0] and the enable from cfg_wdata[8]. cfg_sel 1 loads the buffer pointer, cfg_sel 2 loads the I/O pointer from cfg_wdata[15:0], and cfg_sel 3 loads the count from cfg_wdata[15:0]. Writes made while a transfer is in progress (bus_req high) are ignored.
- R3: The control field is mapped as follows: bit0 = early end permitted, bit1 = direction (0 = I/O to buffer, 1 = buffer to I/O), bit2 = buffer pointer fixed, bit3 = word size, bit4 = I/O pointer fixed. ctrl_out[7:5] always reads 0, whatever was written to those bits.
- R4: A transfer first reads at the source address (bus_we 0), then writes at the destination address (bus_we 1). The I/O address appears on the bus as {8'h00, io pointer}. bus_word equals control bit3. In byte mode the write data is the low byte that was read, zero-extended.
- R5: While bus_rdy is low, bus_req, bus_we and bus_addr hold their values.
- R6: After the write cycle is accepted, each pointer that is not marked fixed advances by 1 (byte) or 2 (word). A fixed pointer keeps its value.
- R7: The buffer pointer advances only in its low 16 bits, so bits 23:16 never change except through a register write. The I/O pointer wraps modulo 2^16.
- R8: One cycle after the write cycle is accepted, xfer_ack is high for exactly one cycle and the count has decreased by 1. A request is ignored while the channel is disabled or while xfer_ack is high.
- R9: The transfer that takes the count from 1 to 0 clears the enable and raises done_irq for one cycle, in the same cycle as xfer_ack.
- R10: If control bit0 is set and end_req is high together with a request the channel accepts, no bus cycle occurs. In the next cycle xfer_ack and done_irq are each high for one cycle, the enable is cleared, and the pointers and the count are unchanged. With bit0 clear, end_req has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | 24 | Register write data |
| ctrl_out | output | 8 | Control field readback |
| enabled | output | 1 | Channel enable |
| buf_ptr | output | 24 | Buffer pointer |
| io_ptr | output | 16 | I/O pointer |
| count | output | 16 | Remaining transfers |
| req | input | 1 | Peripheral transfer request |
| end_req | input | 1 | Peripheral early-end request |
| xfer_ack | output | 1 | Peripheral acknowledge pulse |
| done_irq | output | 1 | Completion interrupt pulse |
| bus_req | output | 1 | Bus cycle active |
| bus_we | output | 1 | Bus write (1) or read (0) |
| bus_word | output | 1 | Word (1) or byte (0) access |
| bus_addr | output | 24 | Bus address |
| bus_wdata | output | 16 | Bus write data |
| bus_rdata | input | 16 | Bus read data |
| bus_rdy | input | 1 | Bus cycle complete |

## Verification
An accepted request raises bus_req one cycle later, and each bus cycle finishes on the clock edge where bus_rdy is seen high. Pointer updates, the count decrement, xfer_ack and done_irq all appear one cycle after the write cycle finishes. An early end shows its acknowledge and interrupt one cycle after the request is accepted. The bench steps a behavioural model on the same clock edges as the design, with the memory responder inserting 0 or 2 wait cycles, and compares every output at the following falling edge. The directed scenarios then also check the final pointer and count values against literal constants.

// File: rtl/irq_xfer_channel.sv
module irq_xfer_channel #(
  parameter int AW     = 24,
  parameter int PAGE_W = 16,
  parameter int IOW    = 16,
  parameter int DW     = 16,
  parameter int CW     = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  output logic [7:0]    ctrl_out,
  output logic          enabled,
  output logic [AW-1:0] buf_ptr,
  output logic [IOW-1:0] io_ptr,
  output logic [CW-1:0] count,
  input  logic          req,
  input  logic          end_req,
  output logic          xfer_ack,
  output logic          done_irq,
  output logic          bus_req,
  output logic          bus_we,
  output logic          bus_word,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_rdy
);
  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;
  st_t st;

  logic [4:0]    ctl;
  logic [DW-1:0] dbuf;

  wire term_en = ctl[0];
  wire to_io   = ctl[1];
  wire bp_fix  = ctl[2];
  wire word    = ctl[3];
  wire io_fix  = ctl[4];

  wire              idle    = (st == S_IDLE);
  wire              start   = idle && enabled && req && !xfer_ack;
  wire              stop_pe = start && term_en && end_req;
  wire [PAGE_W-1:0] step    = word ? PAGE_W'(2) : PAGE_W'(1);
  wire [AW-1:0]     io_addr = {{(AW-IOW){1'b0}}, io_ptr};

  assign ctrl_out  = {3'b000, ctl};
  assign bus_req   = !idle;
  assign bus_we    = (st == S_WR);
  assign bus_word  = word;
  assign bus_addr  = ((st == S_RD) == to_io) ? buf_ptr : io_addr;
  assign bus_wdata = dbuf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      ctl <= '0;
      enabled <= 1'b0;
      buf_ptr <= '0;
      io_ptr <= '0;
      count <= '0;
      dbuf <= '0;
      xfer_ack <= 1'b0;
      done_irq <= 1'b0;
    end else begin
      xfer_ack <= 1'b0;
      done_irq <= 1'b0;
      if (cfg_we && idle) begin
        case (cfg_sel)
          2'd0: begin ctl <= cfg_wdata[4:0]; enabled <= cfg_wdata[8]; end
          2'd1: buf_ptr <= cfg_wdata;
          2'd2: io_ptr <= cfg_wdata[IOW-1:0];
          default: count <= cfg_wdata[CW-1:0];
        endcase
      end
      case (st)
        S_IDLE: begin
          if (stop_pe) begin
            enabled <= 1'b0;
            xfer_ack <= 1'b1;
            done_irq <= 1'b1;
          end else if (start) begin
            st <= S_RD;
          end
        end
        S_RD: begin
          if (bus_rdy) begin
            dbuf <= word ? bus_rdata : {{(DW-8){1'b0}}, bus_rdata[7:0]};
            st <= S_WR;
          end
        end
        default: begin
          if (bus_rdy) begin
            st <= S_IDLE;
            xfer_ack <= 1'b1;
            count <= count - 1'b1;
            if (!bp_fix) buf_ptr[PAGE_W-1:0] <= buf_ptr[PAGE_W-1:0] + step;
            if (!io_fix) io_ptr <= io_ptr + IOW'(step);
            if (count == CW'(1)) begin
              enabled <= 1'b0;
              done_irq <= 1'b1;
            end
          end
        end
      endcase
    end
  end

  // R8
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ack |=> !xfer_ack);

  // R5
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_rdy) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

  // R7
  page_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && cfg_sel == 2'd1) |=> $stable(buf_ptr[AW-1:PAGE_W]));

  // R9
  irq_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> (!enabled && xfer_ack));

  // R2
  bus_only_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> enabled);
endmodule

// File: tb/irq_xfer_channel_test.sv
`timescale 1ns/1ps
module irq_xfer_channel_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = 2'd0;
  logic [23:0] cfg_wdata = '0;
  logic req = 1'b0, end_req = 1'b0, bus_rdy = 1'b0;
  logic [7:0] ctrl_out;
  logic enabled, xfer_ack, done_irq, bus_req, bus_we, bus_word;
  logic [23:0] buf_ptr, bus_addr;
  logic [15:0] io_ptr, count, bus_wdata, bus_rdata;

  int checks = 0, errors = 0, lat = 0, wcnt = 0;

  always #2.5 clk = ~clk;

  irq_xfer_channel uut (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .ctrl_out(ctrl_out), .enabled(enabled), .buf_ptr(buf_ptr),
    .io_ptr(io_ptr), .count(count), .req(req), .end_req(end_req), .xfer_ack(xfer_ack),
    .done_irq(done_irq), .bus_req(bus_req), .bus_we(bus_we), .bus_word(bus_word),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rdy(bus_rdy));

  assign bus_rdata = bus_addr[15:0] ^ 16'h5A3C;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // memory responder with programmable wait cycles
  always @(negedge clk) begin
    if (bus_req) begin
      if (wcnt >= lat) begin bus_rdy = 1'b1; wcnt = 0; end
      else begin bus_rdy = 1'b0; wcnt++; end
    end else begin
      bus_rdy = 1'b0; wcnt = 0;
    end
  end

  // behavioural reference model
  int ph = 0;
  logic [4:0] m_ctl = '0;
  logic m_en = 1'b0, m_ack = 1'b0, m_irq = 1'b0;
  logic [23:0] m_bp = '0;
  logic [15:0] m_io = '0, m_cnt = '0, m_data = '0;

  function automatic logic [23:0] m_src();
    return m_ctl[1] ? m_bp : {8'h00, m_io};
  endfunction
  function automatic logic [23:0] m_dst();
    return m_ctl[1] ? {8'h00, m_io} : m_bp;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; m_ctl = '0; m_en = 0; m_ack = 0; m_irq = 0;
      m_bp = '0; m_io = '0; m_cnt = '0; m_data = '0;
    end else begin
      automatic logic pa = m_ack;
      automatic int step = m_ctl[3] ? 2 : 1;
      m_ack = 0; m_irq = 0;
      if (ph == 0 && cfg_we) begin
        case (cfg_sel)
          2'd0: begin m_ctl = cfg_wdata[4:0]; m_en = cfg_wdata[8]; end
          2'd1: m_bp = cfg_wdata;
          2'd2: m_io = cfg_wdata[15:0];
          default: m_cnt = cfg_wdata[15:0];
        endcase
      end
      if (ph == 0) begin
        if (m_en && req && !pa) begin
          if (m_ctl[0] && end_req) begin m_en = 0; m_ack = 1; m_irq = 1; end
          else ph = 1;
        end
      end else if (ph == 1) begin
        if (bus_rdy) begin
          automatic logic [15:0] rd = m_src() ^ 24'h005A3C;
          m_data = m_ctl[3] ? rd : {8'h00, rd[7:0]};
          ph = 2;
        end
      end else if (bus_rdy) begin
        ph = 0; m_ack = 1;
        if (!m_ctl[2]) m_bp = {m_bp[23:16], 16'(m_bp[15:0] + step)};
        if (!m_ctl[4]) m_io = 16'(m_io + step);
        if (m_cnt == 16'd1) begin m_en = 0; m_irq = 1; end
        m_cnt = m_cnt - 16'd1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3 ctrl_out", 32'(ctrl_out), 32'({3'b000, m_ctl}));
      chk("R2 enabled", 32'(enabled), 32'(m_en));
      chk("R6 buf_ptr", 32'(buf_ptr), 32'(m_bp));
      chk("R6 io_ptr", 32'(io_ptr), 32'(m_io));
      chk("R8 count", 32'(count), 32'(m_cnt));
      chk("R8 xfer_ack", 32'(xfer_ack), 32'(m_ack));
      chk("R9 done_irq", 32'(done_irq), 32'(m_irq));
      chk("R4 bus_req", 32'(bus_req), 32'(ph != 0));
      if (ph != 0) begin
        chk("R4 bus_we", 32'(bus_we), 32'(ph == 2));
        chk("R4 bus_word", 32'(bus_word), 32'(m_ctl[3]));
        chk("R4 bus_addr", 32'(bus_addr), 32'(ph == 1 ? m_src() : m_dst()));
      end
      if (ph == 2) chk("R4 bus_wdata", 32'(bus_wdata), 32'(m_data));
    end
  end

  task automatic wreg(input logic [1:0] s, input logic [23:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic pulse_req(input logic e);
    @(negedge clk); req = 1'b1; end_req = e;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (xfer_ack) break;
    end
    req = 1'b0; end_req = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 enabled", 32'(enabled), 0);
    chk("R1 buf_ptr", 32'(buf_ptr), 0);
    chk("R1 count", 32'(count), 0);
    chk("R1 ctrl", 32'(ctrl_out), 0);
    chk("R1 bus_req", 32'(bus_req), 0);
    chk("R1 ack_irq", 32'({xfer_ack, done_irq}), 0);

    // byte, I/O to buffer, both pointers advance, no wait cycles
    lat = 0;
    wreg(2'd1, 24'h340010); wreg(2'd2, 24'h000200); wreg(2'd3, 24'd3);
    wreg(2'd0, 24'h000100);
    repeat (3) pulse_req(1'b0);
    chk("R6 byte buf_ptr", 32'(buf_ptr), 32'h340013);
    chk("R6 byte io_ptr", 32'(io_ptr), 32'h0203);
    chk("R9 disabled at zero", 32'(enabled), 0);

    // R8 request ignored while disabled
    pulse_req(1'b0);
    chk("R8 ignored count", 32'(count), 0);
    chk("R8 ignored buf_ptr", 32'(buf_ptr), 32'h340013);

    // word, buffer to I/O, buffer fixed, two wait cycles, write while busy
    lat = 2;
    wreg(2'd1, 24'h500100); wreg(2'd2, 24'h000040); wreg(2'd3, 24'd2);
    wreg(2'd0, 24'h10E);
    fork
      pulse_req(1'b0);
      begin repeat (2) @(negedge clk); wreg(2'd1, 24'hABCDEF); end
    join
    pulse_req(1'b0);
    chk("R2 busy write ignored", 32'(buf_ptr), 32'h500100);
    chk("R6 word io_ptr", 32'(io_ptr), 32'h0044);

    // R7 page wrap
    lat = 0;
    wreg(2'd1, 24'h12FFFF); wreg(2'd2, 24'h00FFFF); wreg(2'd3, 24'd5);
    wreg(2'd0, 24'h108);
    pulse_req(1'b0);
    chk("R7 page wrap", 32'(buf_ptr), 32'h120001);
    chk("R7 io wrap", 32'(io_ptr), 32'h0001);
    chk("R7 count", 32'(count), 4);

    // R3 reserved bits
    wreg(2'd0, 24'h0001FF);
    chk("R3 reserved zero", 32'(ctrl_out), 32'h1F);

    // R10 early end permitted
    wreg(2'd0, 24'h111);
    pulse_req(1'b1);
    chk("R10 count kept", 32'(count), 4);
    chk("R10 disabled", 32'(enabled), 0);
    chk("R10 buf kept", 32'(buf_ptr), 32'h120001);

    // R10 early end not permitted; I/O pointer fixed
    wreg(2'd0, 24'h110);
    pulse_req(1'b1);
    chk("R10 end ignored count", 32'(count), 3);
    chk("R10 still enabled", 32'(enabled), 1);
    chk("R6 io fixed", 32'(io_ptr), 32'h0001);
    chk("R6 buf byte step", 32'(buf_ptr), 32'h120002);

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule